// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Three-Bit Instruction Decode

This block is the serial test port of a memory device. A sixteen-state controller advances on the rising edge of the test clock under the mode-select input. The test port has two serial paths. One is a three-bit instruction path. The other is a data path, which routes through one of three registers: an external boundary chain, an internal 32-bit identification register, or a one-bit bypass stage. The serial output changes on the falling edge of the test clock and is enabled only while one of the two shift states is active.

The decoded instruction drives two static outputs to the external boundary cells. The first puts the cells in test mode. The second forces the device outputs to high impedance. Strobes for capture, shift and update of the boundary chain are asserted only while the boundary chain is selected. Any instruction code without a function of its own selects the bypass stage, so the chain length is always defined.

Controller states are: TLR (test-logic-reset) and RTI (run-test/idle). The data column is SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR and UPD_DR. The instruction column is SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR and UPD_IR.

Transitions use the mode-select value sampled at the rising edge:
- TLR goes to RTI on 0 and stays on 1.
- RTI stays on 0 and goes to SEL_DR on 1.
- SEL_DR goes to CAP_DR on 0 and to SEL_IR on 1. SEL_IR goes to CAP_IR on 0 and to TLR on 1.
- CAP_x goes to SH_x on 0 and to EX1_x on 1.
- SH_x stays on 0 and goes to EX1_x on 1.
- EX1_x goes to PAU_x on 0 and to UPD_x on 1.
- PAU_x stays on 0 and goes to EX2_x on 1.
- EX2_x goes to SH_x on 0 and to UPD_x on 1.
- UPD_x goes to RTI on 0 and to SEL_DR on 1.

Top module: `tap_port`

## Requirements
- R1: While trst_n is low, the controller is held in TLR, tdo_en is 0, and the instruction is IDCODE (001). A data scan after reset returns the identification value.
- R2: Five consecutive rising edges with tms high bring the controller to TLR from any state. TLR reloads IDCODE, which clears bsr_mode and bsr_hiz.
- R3: The controller follows the sixteen-state transition graph given above.
- R4: In CAP_IR the instruction shift stage loads 001. The first three bits shifted out are therefore 1, 0, 0, least significant bit first. The shifted-in code takes effect on the falling edge in UPD_IR.
- R5: Under IDCODE (001), the data scan shifts out 32'h40014021, least significant bit first. The fields from the top are: version 4'h4, part 16'h0014, maker 11'h010, and a 1 at bit 0.
- R6: Under BYPASS (111), the first data bit out is 0, captured in CAP_DR. Each later bit out equals the tdi value sampled at the rising edge just before it.
- R7: Reserved codes 011, 101 and 110 behave exactly as BYPASS. Exactly one data register is selected at all times.
- R8: Codes 000 (EXTEST), 010 (sample with outputs off) and 100 (SAMPLE/PRELOAD) route the boundary chain. While in SH_DR, tdo shows bsr_tdo and bsr_shift is high.
- R9: bsr_mode is high only for codes 000 and 010. bsr_hiz is high only for code 010.
- R10: tdo and tdo_en are updated on the falling edge of tck. tdo_en is high only after a falling edge in SH_DR or SH_IR. In SH_IR, tdo carries the instruction shift stage.
- R11: bsr_capture is high only in CAP_DR and bsr_update only in UPD_DR, and each only while a boundary instruction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, valid when tdo_en is high |
| tdo_en | output | 1 | Output enable for tdo, high in shift states |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_mode | output | 1 | Boundary cells drive pins in test mode |
| bsr_hiz | output | 1 | Force device outputs to high impedance |

## Verification
The assertions assume that tms and tdi change only away from the rising edge of tck. They also assume that trst_n is low at time zero and released between edges. They take bsr_tdo as an opaque serial bit, and check only that tdo follows it when the boundary path is selected. The bench drives every input shortly after a falling edge and holds it across the next rising edge. It samples outputs just after the following falling edge. It walks all eight instruction codes through full IR and DR scans, and it forces TLR both with the reset pin and with runs of tms high.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_t;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] OP_EXTEST     = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE     = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_HIZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE     = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS     = 3'b111;

    localparam logic [IR_W-1:0] IR_CAPTURE    = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       capture_dr,
    output logic       shift_dr,
    output logic       update_dr,
    output logic       capture_ir,
    output logic       shift_ir,
    output logic       update_ir
);

    tap_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            TLR:    nxt = tms ? TLR    : RTI;
            RTI:    nxt = tms ? SEL_DR : RTI;
            SEL_DR: nxt = tms ? SEL_IR : CAP_DR;
            CAP_DR: nxt = tms ? EX1_DR : SH_DR;
            SH_DR:  nxt = tms ? EX1_DR : SH_DR;
            EX1_DR: nxt = tms ? UPD_DR : PAU_DR;
            PAU_DR: nxt = tms ? EX2_DR : PAU_DR;
            EX2_DR: nxt = tms ? UPD_DR : SH_DR;
            UPD_DR: nxt = tms ? SEL_DR : RTI;
            SEL_IR: nxt = tms ? TLR    : CAP_IR;
            CAP_IR: nxt = tms ? EX1_IR : SH_IR;
            SH_IR:  nxt = tms ? EX1_IR : SH_IR;
            EX1_IR: nxt = tms ? UPD_IR : PAU_IR;
            PAU_IR: nxt = tms ? EX2_IR : PAU_IR;
            EX2_IR: nxt = tms ? UPD_IR : SH_IR;
            UPD_IR: nxt = tms ? SEL_DR : RTI;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TLR;
        else         state <= nxt;
    end

    always_comb begin
        in_reset   = (state == TLR);
        capture_dr = (state == CAP_DR);
        shift_dr   = (state == SH_DR);
        update_dr  = (state == UPD_DR);
        capture_ir = (state == CAP_IR);
        shift_ir   = (state == SH_IR);
        update_ir  = (state == UPD_IR);
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            capture,
    input  logic            shift,
    input  logic            update,
    output logic [IR_W-1:0] ir_sh,
    output logic [IR_W-1:0] ir,
    output logic            sel_bsr,
    output logic            sel_id,
    output logic            sel_byp,
    output logic            mode,
    output logic            hiz
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)      ir_sh <= IR_CAPTURE;
        else if (capture) ir_sh <= IR_CAPTURE;
        else if (shift)   ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)       ir <= OP_IDCODE;
        else if (in_reset) ir <= OP_IDCODE;
        else if (update)   ir <= ir_sh;
    end

    always_comb begin
        sel_bsr = 1'b0;
        sel_id  = 1'b0;
        sel_byp = 1'b0;
        mode    = 1'b0;
        hiz     = 1'b0;
        unique case (ir)
            OP_EXTEST:     begin sel_bsr = 1'b1; mode = 1'b1; end
            OP_SAMPLE_HIZ: begin sel_bsr = 1'b1; mode = 1'b1; hiz = 1'b1; end
            OP_SAMPLE:     sel_bsr = 1'b1;
            OP_IDCODE:     sel_id  = 1'b1;
            default:       sel_byp = 1'b1;
        endcase
    end

endmodule

// File: rtl/tap_dr.sv
module tap_dr #(
    parameter int          ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = '1
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tdi,
    input  logic capture,
    input  logic shift,
    input  logic sel_id,
    input  logic sel_byp,
    output logic id_lsb,
    output logic byp_q
);

    logic [ID_W-1:0] id_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                id_sr <= ID_VAL;
        else if (capture && sel_id) id_sr <= ID_VAL;
        else if (shift && sel_id)   id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 byp_q <= 1'b0;
        else if (capture && sel_byp) byp_q <= 1'b0;
        else if (shift && sel_byp)   byp_q <= tdi;
    end

    assign id_lsb = id_sr[0];

endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_pkg::*;
#(
    parameter logic [3:0]  VERSION = 4'h4,
    parameter logic [15:0] PART    = 16'h0014,
    parameter logic [10:0] MAKER   = 11'h010
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    input  logic bsr_tdo,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic bsr_mode,
    output logic bsr_hiz
);

    localparam logic [31:0] ID_WORD = {VERSION, PART, MAKER, 1'b1};
    localparam int          ID_W    = $bits(ID_WORD);

    tap_state_t      state_w;
    logic            in_reset, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
    logic [IR_W-1:0] ir_sh_w, ir_w;
    logic            sel_bsr, sel_id, sel_byp;
    logic            id_lsb, byp_q, dr_bit, tdo_nxt;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state_w),
        .in_reset(in_reset), .capture_dr(cap_dr), .shift_dr(sh_dr),
        .update_dr(upd_dr), .capture_ir(cap_ir), .shift_ir(sh_ir),
        .update_ir(upd_ir)
    );

    tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
        .capture(cap_ir), .shift(sh_ir), .update(upd_ir),
        .ir_sh(ir_sh_w), .ir(ir_w), .sel_bsr(sel_bsr), .sel_id(sel_id),
        .sel_byp(sel_byp), .mode(bsr_mode), .hiz(bsr_hiz)
    );

    tap_dr #(.ID_W(ID_W), .ID_VAL(ID_WORD)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture(cap_dr),
        .shift(sh_dr), .sel_id(sel_id), .sel_byp(sel_byp),
        .id_lsb(id_lsb), .byp_q(byp_q)
    );

    always_comb begin
        if (sel_bsr)     dr_bit = bsr_tdo;
        else if (sel_id) dr_bit = id_lsb;
        else             dr_bit = byp_q;
        tdo_nxt = sh_ir ? ir_sh_w[0] : dr_bit;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= tdo_nxt;
            tdo_en <= sh_ir | sh_dr;
        end
    end

    assign bsr_capture = cap_dr & sel_bsr;
    assign bsr_shift   = sh_dr  & sel_bsr;
    assign bsr_update  = upd_dr & sel_bsr;

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic            tdo_en,
    input logic            bsr_capture,
    input logic            bsr_update,
    input logic            bsr_mode,
    input logic            bsr_hiz,
    input tap_state_t      state,
    input logic [IR_W-1:0] ir_sh,
    input logic [2:0]      sels
);

    logic [2:0] ones_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       ones_run <= '0;
        else if (!tms)     ones_run <= '0;
        else if (ones_run != 3'd7) ones_run <= ones_run + 3'd1;
    end

    p_five_ones_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run >= 3'd5) |-> (state == TLR));

    p_tlr_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TLR && tms) |=> (state == TLR));

    p_capir_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == CAP_IR) |=> (ir_sh == IR_CAPTURE));

    p_one_sel_r7: assert property (@(posedge tck) disable iff (!trst_n)
        $countones(sels) == 1);

    p_hiz_mode_r9: assert property (@(posedge tck) disable iff (!trst_n)
        bsr_hiz |-> bsr_mode);

    p_tdo_en_r10: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (state == SH_DR || state == SH_IR));

    p_cap_state_r11: assert property (@(posedge tck) disable iff (!trst_n)
        bsr_capture |-> (state == CAP_DR));

    p_upd_state_r11: assert property (@(posedge tck) disable iff (!trst_n)
        bsr_update |-> (state == UPD_DR));

endmodule

bind tap_port tap_port_chk u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_en(tdo_en),
    .bsr_capture(bsr_capture), .bsr_update(bsr_update),
    .bsr_mode(bsr_mode), .bsr_hiz(bsr_hiz), .state(state_w),
    .ir_sh(ir_sh_w), .sels({sel_bsr, sel_id, sel_byp})
);

// File: tb/test_tap_port.sv
module test_tap_port;

    localparam int          CLK_PERIOD = 100;
    localparam logic [31:0] ID_EXP     = 32'h40014021;
    // fields: [6:4] opcode, [3:2] path (0 boundary, 1 id, 2 bypass), [1] mode, [0] hiz
    localparam logic [6:0] VEC [8] = '{
        7'b000_00_10, 7'b001_01_00, 7'b010_00_11, 7'b011_10_00,
        7'b100_00_00, 7'b101_10_00, 7'b110_10_00, 7'b111_10_00
    };

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_tdo = 1'b0;
    logic tdo, tdo_en, bsr_capture, bsr_shift, bsr_update, bsr_mode, bsr_hiz;
    int   total = 0, bad = 0;

    tap_port i_tap_port (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_en(tdo_en), .bsr_tdo(bsr_tdo), .bsr_capture(bsr_capture),
        .bsr_shift(bsr_shift), .bsr_update(bsr_update),
        .bsr_mode(bsr_mode), .bsr_hiz(bsr_hiz)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    // from RTI, load an opcode and return to RTI; checks captured pattern
    task automatic load_ir(input logic [2:0] op);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        chk(tdo_en === 1'b1, "R10", tdo_en, 1);
        chk(tdo === 1'b1, "R4", tdo, 1);
        step(0, op[0]); chk(tdo === 1'b0, "R4", tdo, 0);
        step(0, op[1]); chk(tdo === 1'b0, "R4", tdo, 0);
        step(1, op[2]); chk(tdo_en === 1'b0, "R10", tdo_en, 0);
        step(1, 0);
        step(0, 0);
    endtask

    // from RTI, 32-bit data scan, path: 0 boundary, 1 id, 2 bypass
    task automatic scan_dr(input logic [1:0] path);
        logic [31:0] pat = 32'hC3A5_96E1;
        step(1, 0); step(0, 0);
        chk(bsr_capture === (path == 2'd0), "R11", bsr_capture, path == 2'd0);
        bsr_tdo = pat[0];
        step(0, 0);
        for (int i = 0; i < 32; i++) begin
            logic exp;
            if (i > 0) begin
                bsr_tdo = ~pat[i];
                step(0, pat[i]);
            end
            if (path == 2'd0)      exp = bsr_tdo;
            else if (path == 2'd1) exp = ID_EXP[i];
            else                   exp = (i == 0) ? 1'b0 : pat[i];
            if (path == 2'd0)      chk(tdo === exp && bsr_shift === 1'b1, "R8", tdo, exp);
            else if (path == 2'd1) chk(tdo === exp, "R5", tdo, exp);
            else                   chk(tdo === exp && bsr_shift === 1'b0, "R6 R7", tdo, exp);
        end
        step(1, 0);
        step(1, 0);
        chk(bsr_update === (path == 2'd0), "R11", bsr_update, path == 2'd0);
        step(0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3 + 7);
        // R1: reset state
        chk(tdo_en === 1'b0, "R1", tdo_en, 0);
        chk(bsr_mode === 1'b0 && bsr_hiz === 1'b0, "R1", {bsr_mode, bsr_hiz}, 0);
        @(negedge tck); #1;
        trst_n = 1'b1;
        step(0, 0);
        scan_dr(2'd1);  // R1 default IDCODE

        // table walk over all codes (R3 path through both columns)
        foreach (VEC[k]) begin
            load_ir(VEC[k][6:4]);
            chk(bsr_mode === VEC[k][1], "R9", bsr_mode, VEC[k][1]);
            chk(bsr_hiz === VEC[k][0], "R9", bsr_hiz, VEC[k][0]);
            scan_dr(VEC[k][3:2]);
        end

        // R2: five ones from Shift-DR under the hiz code
        load_ir(3'b010);
        step(1, 0); step(0, 0); step(0, 0);
        chk(tdo_en === 1'b1, "R10", tdo_en, 1);
        for (int j = 0; j < 5; j++) step(1, 0);
        chk(bsr_mode === 1'b0 && bsr_hiz === 1'b0, "R2", {bsr_mode, bsr_hiz}, 0);
        chk(tdo_en === 1'b0, "R2", tdo_en, 0);
        step(0, 0);
        scan_dr(2'd1);

        // R3: pause and exit2 loop back into Shift-DR under bypass
        load_ir(3'b111);
        step(1, 0); step(0, 0); step(0, 0);
        step(1, 1); step(0, 1); step(0, 1);
        chk(tdo_en === 1'b0, "R3", tdo_en, 0);
        step(1, 1); step(0, 1);
        chk(tdo_en === 1'b1 && tdo === 1'b1, "R3", {tdo_en, tdo}, 2'b11);
        step(1, 0); step(1, 0); step(0, 0);

        // R1: asynchronous reset mid-scan from EXTEST
        load_ir(3'b000);
        chk(bsr_mode === 1'b1, "R9", bsr_mode, 1);
        step(1, 0); step(0, 0); step(0, 0);
        #3 trst_n = 1'b0;
        #2;
        chk(tdo_en === 1'b0 && bsr_mode === 1'b0, "R1", {tdo_en, bsr_mode}, 0);
        @(negedge tck); #1;
        trst_n = 1'b1;
        step(0, 0);
        scan_dr(2'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule